// File: doc/BRIEF.md
# CIC Decimator with Scaled Saturating Output

This block is a cascaded integrator-comb decimation filter for a stream of 14-bit signed samples. A chain of one to five integrators runs at the input rate. A counter picks every ratio-th integrated value, and an equal number of comb stages run at that reduced rate. The internal data path is 26 bits wide, which is less than the full growth of the largest configurations. All arithmetic inside the filter is two's-complement modular, so intermediate wrap-around does no harm as long as the final filtered value fits in 26 bits.

Each filtered result goes through a scale stage before it leaves the block. The scale stage is an arithmetic right shift of 0 to 7 places with round-half-up. A clamp then limits the value to the signed 24-bit range, so that it fits the word a downstream buffer expects. When the clamp acts and reporting is enabled, a sticky saturation flag is set. The flag stays set until an explicit clear. With reporting disabled, clamped data still flows. The order, ratio and shift are set before a run and held steady during it.

Top module: `cic_decim_scale`

## Requirements
- R1: The filter order follows `cfg_order` (1 to 5; 0 acts as 1, values above 5 act as 5). Each decimated result equals an order-fold running sum of the input, followed by an order-fold first difference taken at the decimated rate. For a constant input x in steady state, the result is x times ratio to the power of order.
- R2: The decimation ratio follows `cfg_ratio` (2 to 15; 0 and 1 act as 2). Exactly one result is formed per ratio accepted samples. Cycles with `in_valid` low are ignored whatever `in_sample` holds. `out_valid` is never high on two consecutive cycles.
- R3: Integrators and combs wrap modulo 2^26. A long constant input that overflows the integrators many times still yields the exact steady-state result when that result fits in 26 bits.
- R4: The scale stage adds 2^(s-1) when s > 0 and then shifts arithmetically right by s = `cfg_shift`. This rounds halves toward plus infinity (for s = 2: 6 gives 2, -6 gives -1, -2 gives 0).
- R5: The scaled value is clamped to the range -8388608 to 8388607 and put out on `out_data` in two's complement.
- R6: `sat_flag` is set on the cycle a clamped result is put out while `sat_en` is 1. It stays set through later unclamped results. A one-cycle `sat_clr` clears it. If a clamp and a clear fall on the same cycle, the set wins.
- R7: With `sat_en` at 0, a clamped result still appears on `out_data` with `out_valid`, and `sat_flag` does not rise.
- R8: After reset, the first `order` decimated results are dropped, and only later ones are put out.
- R9: `out_valid` pulses on the second rising edge after the edge that accepts the last sample of a frame.
- R10: During and right after reset, `out_valid`, `out_data` and `sat_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample qualifier |
| in_sample | input | 14 | Signed input sample |
| cfg_order | input | 3 | Filter order |
| cfg_ratio | input | 4 | Decimation ratio |
| cfg_shift | input | 3 | Right-shift amount of the scale stage |
| sat_en | input | 1 | Enables saturation reporting |
| sat_clr | input | 1 | Clears the saturation flag |
| out_valid | output | 1 | Output qualifier, one-cycle pulse |
| out_data | output | 24 | Scaled and clamped result |
| sat_flag | output | 1 | Sticky saturation indication |

## Verification
The assertions check on every cycle that:
- the integrator and comb state holds while no sample or decimated result arrives;
- outputs are isolated one-cycle pulses, each preceded by a decimation strobe;
- the flag only rises on a clamped extreme output, stays set until cleared, and cannot rise while reporting is masked.

Only the scenarios can show the arithmetic: the gain for each order and ratio, the effect of modular wrap, the rounding of halves, the count of dropped warm-up results and the exact output cycle. The bench checks these against its own model of the requirements and against hand-computed constants.

// File: rtl/cicd_pkg.sv
package cicd_pkg;
    localparam int unsigned CICD_IN_W      = 14;
    localparam int unsigned CICD_ACC_W     = 26;
    localparam int unsigned CICD_OUT_W     = 24;
    localparam int unsigned CICD_MAX_ORDER = 5;
    localparam int unsigned CICD_RATIO_W   = 4;
    localparam int unsigned CICD_SHIFT_W   = 3;

    // Outcome of the range check in the scale stage
    typedef enum logic [1:0] {
        CLAMP_NONE = 2'd0,
        CLAMP_HIGH = 2'd1,
        CLAMP_LOW  = 2'd2
    } clamp_e;
endpackage

// File: rtl/cicd_integ.sv
// Integrator chain at the input rate; stages at or above the active order hold.
module cicd_integ #(
    parameter int unsigned IN_W      = 14,
    parameter int unsigned ACC_W     = 26,
    parameter int unsigned MAX_ORDER = 5,
    parameter int unsigned ORD_W     = $clog2(MAX_ORDER + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_sample,
    input  logic [ORD_W-1:0] order,
    output logic [ACC_W-1:0] sum_o
);
    typedef struct packed {
        logic [MAX_ORDER-1:0][ACC_W-1:0] acc;
    } integ_st_t;

    integ_st_t st_d, st_q;
    logic [MAX_ORDER-1:0][ACC_W-1:0] chain;

    always_comb begin
        chain[0] = st_q.acc[0] + ACC_W'($signed(in_sample));
        for (int k = 1; k < MAX_ORDER; k++) begin
            chain[k] = st_q.acc[k] + chain[k-1];
        end
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < MAX_ORDER; k++) begin
            if (in_valid && (k < int'(order))) begin
                st_d.acc[k] = chain[k];
            end
        end
        sum_o = chain[order - 1'b1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_INTEG_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q)); // R2
endmodule

// File: rtl/cicd_comb.sv
// Comb chain at the decimated rate; each stage subtracts its previous input.
module cicd_comb #(
    parameter int unsigned ACC_W     = 26,
    parameter int unsigned MAX_ORDER = 5,
    parameter int unsigned ORD_W     = $clog2(MAX_ORDER + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [ACC_W-1:0] dec_data,
    input  logic [ORD_W-1:0] order,
    output logic [ACC_W-1:0] diff_o
);
    typedef struct packed {
        logic [MAX_ORDER-1:0][ACC_W-1:0] dly;
    } comb_st_t;

    comb_st_t st_d, st_q;
    logic [MAX_ORDER-1:0][ACC_W-1:0] stage_in;
    logic [MAX_ORDER-1:0][ACC_W-1:0] stage_out;

    always_comb begin
        stage_in[0]  = dec_data;
        stage_out[0] = dec_data - st_q.dly[0];
        for (int k = 1; k < MAX_ORDER; k++) begin
            stage_in[k]  = stage_out[k-1];
            stage_out[k] = stage_out[k-1] - st_q.dly[k];
        end
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < MAX_ORDER; k++) begin
            if (dec_valid && (k < int'(order))) begin
                st_d.dly[k] = stage_in[k];
            end
        end
        diff_o = stage_out[order - 1'b1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_COMB_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |=> $stable(st_q)); // R1
endmodule

// File: rtl/cicd_scale.sv
// Rounded arithmetic right shift, clamp to the output range, sticky flag.
module cicd_scale
    import cicd_pkg::*;
#(
    parameter int unsigned ACC_W   = 26,
    parameter int unsigned OUT_W   = 24,
    parameter int unsigned SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               res_valid,
    input  logic [ACC_W-1:0]   res_data,
    input  logic [SHIFT_W-1:0] shift,
    input  logic               sat_en,
    input  logic               sat_clr,
    output logic               out_valid,
    output logic [OUT_W-1:0]   out_data,
    output logic               sat_flag
);
    localparam int unsigned EXT_W = ACC_W + 1;
    localparam logic signed [EXT_W-1:0] LIM_HI =
        {{(EXT_W - OUT_W + 1){1'b0}}, {(OUT_W - 1){1'b1}}};
    localparam logic signed [EXT_W-1:0] LIM_LO = ~LIM_HI;

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] data;
        logic             sat;
    } scale_st_t;

    scale_st_t st_d, st_q;
    logic signed [EXT_W-1:0] widened;
    logic signed [EXT_W-1:0] bias;
    logic signed [EXT_W-1:0] shifted;
    clamp_e                  clamp;

    always_comb begin
        widened = EXT_W'($signed(res_data));
        bias    = (shift == '0) ? '0 : (EXT_W'(1) << (shift - 1'b1));
        shifted = (widened + bias) >>> shift;
        if (shifted > LIM_HI)      clamp = CLAMP_HIGH;
        else if (shifted < LIM_LO) clamp = CLAMP_LOW;
        else                       clamp = CLAMP_NONE;
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = res_valid;
        if (res_valid) begin
            unique case (clamp)
                CLAMP_HIGH: st_d.data = LIM_HI[OUT_W-1:0];
                CLAMP_LOW:  st_d.data = LIM_LO[OUT_W-1:0];
                default:    st_d.data = shifted[OUT_W-1:0];
            endcase
        end
        if (res_valid && sat_en && (clamp != CLAMP_NONE)) st_d.sat = 1'b1;
        else if (sat_clr)                                 st_d.sat = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
    assign sat_flag  = st_q.sat;

    AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !sat_clr) |=> sat_flag); // R6
    AST_SAT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_en && !sat_flag) |=> !sat_flag); // R7
    AST_SAT_ON_EXTREME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_flag) |-> (out_valid && ((out_data == LIM_HI[OUT_W-1:0]) ||
                                           (out_data == LIM_LO[OUT_W-1:0])))); // R5
endmodule

// File: rtl/cic_decim_scale.sv
module cic_decim_scale
    import cicd_pkg::*;
#(
    parameter int unsigned IN_W      = CICD_IN_W,
    parameter int unsigned ACC_W     = CICD_ACC_W,
    parameter int unsigned OUT_W     = CICD_OUT_W,
    parameter int unsigned MAX_ORDER = CICD_MAX_ORDER,
    parameter int unsigned RATIO_W   = CICD_RATIO_W,
    parameter int unsigned SHIFT_W   = CICD_SHIFT_W,
    parameter int unsigned ORD_W     = $clog2(MAX_ORDER + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [IN_W-1:0]    in_sample,
    input  logic [ORD_W-1:0]   cfg_order,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic [SHIFT_W-1:0] cfg_shift,
    input  logic               sat_en,
    input  logic               sat_clr,
    output logic               out_valid,
    output logic [OUT_W-1:0]   out_data,
    output logic               sat_flag
);
    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic               dec_vld;
        logic [ACC_W-1:0]   dec;
        logic [ORD_W-1:0]   warm;
    } top_st_t;

    top_st_t            st_d, st_q;
    logic [ORD_W-1:0]   ord_eff;
    logic [RATIO_W-1:0] ratio_eff;
    logic [ACC_W-1:0]   integ_sum;
    logic [ACC_W-1:0]   comb_diff;
    logic               emit;

    // Out-of-range settings are folded onto the nearest legal value
    always_comb begin
        if (cfg_order == '0)                        ord_eff = ORD_W'(1);
        else if (cfg_order > ORD_W'(MAX_ORDER))     ord_eff = ORD_W'(MAX_ORDER);
        else                                        ord_eff = cfg_order;
        ratio_eff = (cfg_ratio < RATIO_W'(2)) ? RATIO_W'(2) : cfg_ratio;
    end

    always_comb begin
        st_d         = st_q;
        st_d.dec_vld = 1'b0;
        if (in_valid) begin
            if (st_q.cnt == ratio_eff - 1'b1) begin
                st_d.cnt     = '0;
                st_d.dec_vld = 1'b1;
                st_d.dec     = integ_sum;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (st_q.dec_vld && (st_q.warm < ord_eff)) st_d.warm = st_q.warm + 1'b1;
        emit = st_q.dec_vld && (st_q.warm >= ord_eff);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cicd_integ #(
        .IN_W(IN_W), .ACC_W(ACC_W), .MAX_ORDER(MAX_ORDER), .ORD_W(ORD_W)
    ) u_integ (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .order(ord_eff), .sum_o(integ_sum)
    );

    cicd_comb #(
        .ACC_W(ACC_W), .MAX_ORDER(MAX_ORDER), .ORD_W(ORD_W)
    ) u_comb (
        .clk(clk), .rst_n(rst_n), .dec_valid(st_q.dec_vld), .dec_data(st_q.dec),
        .order(ord_eff), .diff_o(comb_diff)
    );

    cicd_scale #(
        .ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT_W(SHIFT_W)
    ) u_scale (
        .clk(clk), .rst_n(rst_n), .res_valid(emit), .res_data(comb_diff),
        .shift(cfg_shift), .sat_en(sat_en), .sat_clr(sat_clr),
        .out_valid(out_valid), .out_data(out_data), .sat_flag(sat_flag)
    );

    AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R2
    AST_OUT_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(st_q.dec_vld)); // R9
endmodule

// File: tb/cic_decim_scale_tb.sv
module cic_decim_scale_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [13:0] in_sample = '0;
    logic [2:0]  cfg_order = 3'd5;
    logic [3:0]  cfg_ratio = 4'd4;
    logic [2:0]  cfg_shift = '0;
    logic        sat_en = 1'b1;
    logic        sat_clr = 1'b0;
    logic        out_valid;
    logic [23:0] out_data;
    logic        sat_flag;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    cic_decim_scale u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .cfg_order(cfg_order), .cfg_ratio(cfg_ratio), .cfg_shift(cfg_shift),
        .sat_en(sat_en), .sat_clr(sat_clr),
        .out_valid(out_valid), .out_data(out_data), .sat_flag(sat_flag)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Captured outputs
    int cap_val [1024];
    int cap_cyc [1024];
    int cap_n = 0;
    always @(negedge clk) begin
        if (rst_n && out_valid && cap_n < 1024) begin
            cap_val[cap_n] = $signed(out_data);
            cap_cyc[cap_n] = cyc;
            cap_n = cap_n + 1;
        end
    end

    // Bench model built from the requirements
    logic signed [25:0] m_acc [5];
    logic signed [25:0] m_dly [5];
    int m_ord, m_ratio, m_shift, m_cnt, m_warm;
    int exp_val [1024];
    int exp_cyc [1024];
    int exp_n = 0;
    logic [31:0] rng = 32'h1234_5678;

    function automatic int scale_ref(logic signed [25:0] v, int sh);
        longint t = v;
        if (sh > 0) t = t + (longint'(1) << (sh - 1));
        t = t >>> sh;
        if (t > 8388607)  t = 8388607;
        if (t < -8388608) t = -8388608;
        return int'(t);
    endfunction

    function automatic logic [13:0] rnd14();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng[13:0];
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic model_in(logic signed [13:0] x, int c);
        logic signed [25:0] v;
        logic signed [25:0] t;
        v = x;
        for (int k = 0; k < m_ord; k++) begin
            m_acc[k] = m_acc[k] + v;
            v = m_acc[k];
        end
        m_cnt++;
        if (m_cnt == m_ratio) begin
            m_cnt = 0;
            for (int k = 0; k < m_ord; k++) begin
                t = v - m_dly[k];
                m_dly[k] = v;
                v = t;
            end
            if (m_warm < m_ord) m_warm++;
            else begin
                exp_val[exp_n] = scale_ref(v, m_shift);
                exp_cyc[exp_n] = c + 2;
                exp_n++;
            end
        end
    endtask

    task automatic restart(int ord, int ratio, int sh, bit en);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; sat_clr = 1'b0;
        cfg_order = 3'(ord); cfg_ratio = 4'(ratio); cfg_shift = 3'(sh); sat_en = en;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 5; k++) begin m_acc[k] = '0; m_dly[k] = '0; end
        m_ord = ord; m_ratio = ratio; m_shift = sh; m_cnt = 0; m_warm = 0;
        exp_n = 0; cap_n = 0;
    endtask

    task automatic send(logic signed [13:0] x);
        @(negedge clk);
        in_valid = 1'b1; in_sample = x;
        model_in(x, cyc);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_sample = rnd14();
    endtask

    task automatic drain_and_compare(string req);
        int mism = 0;
        int first = -1;
        idle();
        repeat (4) @(negedge clk);
        check(cap_n == exp_n, req, "output count", cap_n, exp_n);
        for (int i = 0; i < cap_n && i < exp_n; i++) begin
            if (cap_val[i] != exp_val[i] || cap_cyc[i] != exp_cyc[i]) begin
                mism++;
                if (first < 0) first = i;
            end
        end
        if (first >= 0)
            $display("  mismatch at %0d: value %0d/%0d cycle %0d/%0d", first,
                     cap_val[first], exp_val[first], cap_cyc[first], exp_cyc[first]);
        check(mism == 0, req, "stream mismatches", mism, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        restart(5, 4, 0, 1);
        check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
        check(out_data == '0,    "R10", "out_data after reset", out_data, 0);
        check(sat_flag == 1'b0,  "R10", "sat_flag after reset", sat_flag, 0);
    endtask

    task automatic t_dc_full_scale();
        restart(5, 4, 0, 1);
        repeat (40) send(14'sd8191);
        drain_and_compare("R1 R9");
        check(cap_val[cap_n-1] == 8387584, "R1", "order5 ratio4 positive DC", cap_val[cap_n-1], 8387584);
        check(sat_flag == 1'b0, "R5", "no clamp at +full scale", sat_flag, 0);
        restart(5, 4, 0, 1);
        repeat (40) send(-14'sd8192);
        drain_and_compare("R1");
        check(cap_val[cap_n-1] == -8388608, "R1", "order5 ratio4 negative DC", cap_val[cap_n-1], -8388608);
        check(sat_flag == 1'b0, "R5", "no clamp at -full scale", sat_flag, 0);
    endtask

    task automatic t_ratio5_shift();
        restart(5, 5, 2, 1);
        repeat (40) send(14'sd8191);
        drain_and_compare("R2 R4");
        check(cap_val[cap_n-1] == 6399219, "R4", "ratio5 shift2 rounded DC", cap_val[cap_n-1], 6399219);
        check(sat_flag == 1'b0, "R4", "no clamp after scaling", sat_flag, 0);
    endtask

    task automatic t_clamp_sticky();
        restart(5, 5, 0, 1);
        repeat (40) send(14'sd8191);
        drain_and_compare("R5");
        check(cap_val[cap_n-1] == 8388607, "R5", "clamped high value", cap_val[cap_n-1], 8388607);
        check(sat_flag == 1'b1, "R6", "flag set by clamp", sat_flag, 1);
        repeat (40) send(14'sd0);
        idle();
        repeat (4) @(negedge clk);
        check(cap_val[cap_n-1] == 0, "R6", "unclamped result after zeros", cap_val[cap_n-1], 0);
        check(sat_flag == 1'b1, "R6", "flag sticky through unclamped output", sat_flag, 1);
        sat_clr = 1'b1;
        @(negedge clk);
        sat_clr = 1'b0;
        check(sat_flag == 1'b0, "R6", "flag cleared", sat_flag, 0);
        restart(5, 5, 0, 1);
        check(sat_flag == 1'b0, "R10", "flag cleared by reset", sat_flag, 0);
    endtask

    task automatic t_clamp_low();
        restart(5, 5, 0, 1);
        repeat (40) send(-14'sd8192);
        drain_and_compare("R5");
        check(cap_val[cap_n-1] == -8388608, "R5", "clamped low value", cap_val[cap_n-1], -8388608);
        check(sat_flag == 1'b1, "R6", "flag set by low clamp", sat_flag, 1);
    endtask

    task automatic t_masked();
        restart(5, 5, 0, 0);
        repeat (40) send(14'sd8191);
        drain_and_compare("R7");
        check(cap_n == 3, "R7", "masked outputs still flow", cap_n, 3);
        check(cap_val[cap_n-1] == 8388607, "R7", "masked clamped value", cap_val[cap_n-1], 8388607);
        check(sat_flag == 1'b0, "R7", "flag stays low when masked", sat_flag, 0);
    endtask

    task automatic t_rounding();
        restart(1, 2, 2, 1);
        send(0);   send(0);
        send(3);   send(3);
        send(-3);  send(-3);
        send(1);   send(0);
        send(2);   send(0);
        send(-1);  send(-1);
        drain_and_compare("R4");
        check(cap_val[0] == 2,  "R4", "6 >> 2 rounds up", cap_val[0], 2);
        check(cap_val[1] == -1, "R4", "-6 >> 2 rounds up", cap_val[1], -1);
        check(cap_val[2] == 0,  "R4", "1 >> 2", cap_val[2], 0);
        check(cap_val[3] == 1,  "R4", "2 >> 2 half up", cap_val[3], 1);
        check(cap_val[4] == 0,  "R4", "-2 >> 2 half up", cap_val[4], 0);
    endtask

    task automatic t_warmup();
        restart(4, 3, 0, 1);
        repeat (12) send(14'sd100);
        idle();
        repeat (4) @(negedge clk);
        check(cap_n == 0, "R8", "first order results dropped", cap_n, 0);
        repeat (3) send(14'sd100);
        drain_and_compare("R8");
        check(cap_n == 1, "R8", "first kept result", cap_n, 1);
    endtask

    task automatic t_orders_random();
        restart(3, 4, 0, 1);
        repeat (200) send(rnd14());
        drain_and_compare("R1");
        restart(5, 4, 3, 1);
        repeat (200) send(rnd14());
        drain_and_compare("R1 R4");
        restart(2, 3, 1, 1);
        repeat (60) send(14'sd8191);
        drain_and_compare("R1");
        check(cap_val[cap_n-1] == 36860, "R1", "order2 ratio3 shift1 DC", cap_val[cap_n-1], 36860);
    endtask

    task automatic t_gaps();
        restart(2, 7, 0, 1);
        for (int i = 0; i < 100; i++) begin
            if (i % 3 == 2) idle();
            else            send(rnd14());
        end
        drain_and_compare("R2");
        check(cap_n == 7, "R2", "one result per ratio valid samples", cap_n, 7);
    endtask

    task automatic t_wrap();
        restart(5, 4, 0, 1);
        repeat (2000) send(14'sd8191);
        drain_and_compare("R3");
        check(cap_val[cap_n-1] == 8387584, "R3", "exact result after integrator wrap", cap_val[cap_n-1], 8387584);
    endtask

    initial begin
        #(8 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_dc_full_scale();
        t_ratio5_shift();
        t_clamp_sticky();
        t_clamp_low();
        t_masked();
        t_rounding();
        t_warmup();
        t_orders_random();
        t_gaps();
        t_wrap();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule